// File: doc/BRIEF.md
# Dual Clock Synthesizer Serial Loader

This block programs two write-only frequency synthesizers from one 28-bit configuration word. Each synthesizer takes a 9-bit multiplier and a 3-bit divider code. The output frequency is the multiplier divided by the ratio that the code selects: code 0 gives 1, 1 gives 1.5, 2 gives 2, 3 gives 3, 4 gives 4, 5 gives 6, 6 gives 8 and 7 gives 12. A one-cycle command copies both 12-bit fields at the same instant. The block then shifts them out on two serial ports that run in lockstep. Each port has its own clock, data and latch strobe, and each frame ends with a latch pulse.

The four upper bits of the word choose an internal or external sampling clock for each of the four converter channels. These bits go straight to the clock multiplexer selects and take no part in the serial sequence. A busy output tells the command source when a new load can be accepted.

Top module: `clksyn_loader`

## Requirements
- R1: During reset and after its release, busy, both serial clocks, both latch strobes and both data lines are low. While busy is low, no serial clock or latch strobe is high.
- R2: Port AB sends 12 bits per frame, most significant bit first. The bits are cfg_word[11:9] (divider code) followed by cfg_word[8:0] (multiplier), so the frame equals cfg_word[11:0].
- R3: Port CD sends its frame in the same order, built from cfg_word[23:21] (divider code) followed by cfg_word[20:12] (multiplier), so the frame equals cfg_word[23:12].
- R4: Data changes only when the serial clock falls or while it is low. It is stable for every cycle that the serial clock is high, so the device samples it on the rising edge.
- R5: The serial clock period is SCK_DIV system cycles (SCK_DIV even, at least 4). In each period the clock is low for SCK_DIV/2 cycles and then high for SCK_DIV/2 cycles.
- R6: After the twelfth bit period, the latch strobe is high for exactly SCK_DIV cycles. The serial clock stays low for that whole time.
- R7: Busy rises in the cycle after an accepted command and stays high for 13*SCK_DIV cycles. It falls when the latch strobe ends.
- R8: Both frames come from the word present in the cycle of the accepted command. Later changes to cfg_word do not alter a frame in flight.
- R9: A command that arrives while busy is high is ignored. It produces no extra frame and does not lengthen busy.
- R10: ext_clk_sel[3:0] equals cfg_word[27:24] at all times. Index 3 selects for channel A, 2 for B, 1 for C and 0 for D, with 1 meaning external and 0 meaning internal.
- R11: The two ports run in lockstep: their serial clocks and latch strobes are identical in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_word | input | 28 | Stored configuration word |
| load_cmd | input | 1 | One-cycle load command |
| busy | output | 1 | High from an accepted command until the latch strobe ends |
| sclk_ab | output | 1 | Serial clock, A/B synthesizer |
| sdata_ab | output | 1 | Serial data, A/B synthesizer |
| latch_ab | output | 1 | Latch strobe, A/B synthesizer |
| sclk_cd | output | 1 | Serial clock, C/D synthesizer |
| sdata_cd | output | 1 | Serial data, C/D synthesizer |
| latch_cd | output | 1 | Latch strobe, C/D synthesizer |
| ext_clk_sel | output | 4 | Per-channel sampling clock source selects |

## Verification
The in-line properties watch four things on every cycle: data holding still while the serial clock is high, the serial clock staying low under the latch strobe, quiet outputs while idle, and busy ending only out of a latch period. Other behaviour can only be shown by the bench's scenarios. These are the bit order and field extraction of each frame, the 13-period busy length, the capture of the word at the command while the input changes afterwards, and the dropping of a command issued mid-frame. The scoreboard compares every decoded frame with the expected entry and reports any frame that no command asked for.

// File: rtl/clksyn_pkg.sv
package clksyn_pkg;
  localparam int MULT_W  = 9;
  localparam int CODE_W  = 3;
  localparam int FRAME_W = MULT_W + CODE_W;
  localparam int N_SYN   = 2;
  localparam int SEL_W   = 4;
  localparam int CFG_W   = N_SYN * FRAME_W + SEL_W;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_LATCH = 2'd2
  } seq_state_t;
endpackage

// File: rtl/clksyn_seq.sv
module clksyn_seq
  import clksyn_pkg::*;
#(
  parameter int SCK_DIV = 4,
  parameter int BITS    = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd,
  output logic busy,
  output logic sck,
  output logic latch,
  output logic load,
  output logic shift
);
  localparam int CNT_W = $clog2(SCK_DIV);
  localparam int IDX_W = $clog2(BITS);
  localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(SCK_DIV - 1);
  localparam logic [CNT_W-1:0] CNT_HALF = CNT_W'(SCK_DIV / 2);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(BITS - 1);

  seq_state_t       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             period_end;

  assign period_end = (cnt_q == CNT_MAX);

  // next-state logic
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    idx_d   = idx_q;
    case (state_q)
      ST_IDLE: begin
        if (cmd) begin
          state_d = ST_SHIFT;
          cnt_d   = '0;
          idx_d   = '0;
        end
      end
      ST_SHIFT: begin
        cnt_d = period_end ? '0 : cnt_q + 1'b1;
        if (period_end) begin
          if (idx_q == IDX_LAST) state_d = ST_LATCH;
          else                   idx_d   = idx_q + 1'b1;
        end
      end
      ST_LATCH: begin
        cnt_d = period_end ? '0 : cnt_q + 1'b1;
        if (period_end) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      idx_q   <= idx_d;
    end
  end

  assign busy  = (state_q != ST_IDLE);
  assign sck   = (state_q == ST_SHIFT) && (cnt_q >= CNT_HALF);
  assign latch = (state_q == ST_LATCH);
  assign load  = (state_q == ST_IDLE) && cmd;
  assign shift = (state_q == ST_SHIFT) && period_end && (idx_q != IDX_LAST);

  // R6: serial clock held low under the latch strobe
  p_latch_sck_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    latch |-> !sck);

  // R1: idle port is quiet
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!sck && !latch));

  // R7: busy only ends out of a latch period
  p_busy_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(latch));
endmodule

// File: rtl/clksyn_shift.sv
module clksyn_shift #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         shift,
  input  logic [W-1:0] frame_in,
  input  logic         sck,
  output logic         sdo
);
  logic [W-1:0] sr_q, sr_d;
  logic         sr_en;

  assign sr_en = load | shift;

  always_comb begin
    if (load) sr_d = frame_in;
    else      sr_d = {sr_q[W-2:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sr_q <= '0;
    else if (sr_en) sr_q <= sr_d;
  end

  assign sdo = sr_q[W-1];

  // R4: data stable while the serial clock is high
  p_sdo_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sck && $past(sck)) |-> $stable(sdo));
endmodule

// File: rtl/clksyn_loader.sv
module clksyn_loader
  import clksyn_pkg::*;
#(
  parameter int SCK_DIV = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CFG_W-1:0] cfg_word,
  input  logic             load_cmd,
  output logic             busy,
  output logic             sclk_ab,
  output logic             sdata_ab,
  output logic             latch_ab,
  output logic             sclk_cd,
  output logic             sdata_cd,
  output logic             latch_cd,
  output logic [SEL_W-1:0] ext_clk_sel
);
  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic             sck, latch, load, shift;
  logic [N_SYN-1:0] sdo_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  clksyn_seq #(.SCK_DIV(SCK_DIV), .BITS(FRAME_W)) u_seq (
    .clk   (clk),
    .rst_n (rst_int_n),
    .cmd   (load_cmd),
    .busy  (busy),
    .sck   (sck),
    .latch (latch),
    .load  (load),
    .shift (shift)
  );

  for (genvar g = 0; g < N_SYN; g++) begin : g_port
    clksyn_shift #(.W(FRAME_W)) u_sh (
      .clk      (clk),
      .rst_n    (rst_int_n),
      .load     (load),
      .shift    (shift),
      .frame_in (cfg_word[g*FRAME_W +: FRAME_W]),
      .sck      (sck),
      .sdo      (sdo_vec[g])
    );
  end

  assign sclk_ab     = sck;
  assign sclk_cd     = sck;
  assign latch_ab    = latch;
  assign latch_cd    = latch;
  assign sdata_ab    = sdo_vec[0];
  assign sdata_cd    = sdo_vec[1];
  assign ext_clk_sel = cfg_word[CFG_W-1 -: SEL_W];
endmodule

// File: tb/sim_clksyn_loader.sv
module sim_clksyn_loader;
  localparam int DIV  = 4;
  localparam int HIGH = DIV - DIV / 2;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [27:0] cfg_word;
  logic        load_cmd;
  logic        busy, sclk_ab, sdata_ab, latch_ab, sclk_cd, sdata_cd, latch_cd;
  logic [3:0]  ext_clk_sel;

  int checks = 0;
  int errors = 0;
  int exp_frames = 0;
  int got_frames = 0;
  logic [11:0] q_ab[$];
  logic [11:0] q_cd[$];
  bit mon_on = 1'b0;

  always #2 clk = ~clk;

  clksyn_loader #(.SCK_DIV(DIV)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_word(cfg_word), .load_cmd(load_cmd),
    .busy(busy), .sclk_ab(sclk_ab), .sdata_ab(sdata_ab), .latch_ab(latch_ab),
    .sclk_cd(sclk_cd), .sdata_cd(sdata_cd), .latch_cd(latch_cd),
    .ext_clk_sel(ext_clk_sel)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: decodes frames and timing at the falling system clock edge
  logic [1:0]  sck_p = 2'b00, lat_p = 2'b00, dat_p = 2'b00;
  logic [11:0] sh [2];
  int          nb [2];
  int          hi_cnt = 0, per_cnt = 0, lat_cnt = 0;
  bit          r4_bad = 0, r5_bad = 0, r6_bad = 0, r11_bad = 0;

  always @(negedge clk) begin : mon
    logic [1:0]  s, l, d;
    logic [11:0] e;
    bit          have;
    if (mon_on) begin
      s = {sclk_cd, sclk_ab};
      l = {latch_cd, latch_ab};
      d = {sdata_cd, sdata_ab};
      if (s[0] != s[1] || l[0] != l[1]) r11_bad = 1;
      per_cnt++;
      if (s[0]) hi_cnt++;
      if (!s[0] && sck_p[0]) begin
        if (hi_cnt != HIGH) r5_bad = 1;
        hi_cnt = 0;
      end
      if (l[0]) begin
        lat_cnt++;
        if (s[0]) r6_bad = 1;
      end
      if (!l[0] && lat_p[0]) begin
        check(lat_cnt == DIV, "R6 latch width", lat_cnt, DIV);
        lat_cnt = 0;
      end
      for (int p = 0; p < 2; p++) begin
        if (s[p] && sck_p[p] && d[p] != dat_p[p]) r4_bad = 1;
        if (s[p] && !sck_p[p]) begin
          if (p == 0) begin
            if (nb[0] > 0 && per_cnt != DIV) r5_bad = 1;
            per_cnt = 0;
          end
          sh[p] = {sh[p][10:0], d[p]};
          nb[p]++;
        end
        if (l[p] && !lat_p[p]) begin
          have = 0;
          e = '0;
          if (p == 0) begin
            got_frames++;
            if (q_ab.size() > 0) begin have = 1; e = q_ab.pop_front(); end
          end else begin
            if (q_cd.size() > 0) begin have = 1; e = q_cd.pop_front(); end
          end
          check(nb[p] == 12, (p == 0) ? "R2 bit count" : "R3 bit count", nb[p], 12);
          check(have, "R9 unexpected frame", int'(sh[p]), 0);
          if (have) check(sh[p] == e, (p == 0) ? "R2 frame AB" : "R3 frame CD",
                          int'(sh[p]), int'(e));
          if (p == 0) begin
            check(!r4_bad, "R4 data stable while clock high", r4_bad, 0);
            check(!r5_bad, "R5 clock period", r5_bad, 0);
            check(!r6_bad, "R6 clock low under latch", r6_bad, 0);
            check(!r11_bad, "R11 ports lockstep", r11_bad, 0);
          end
          nb[p] = 0;
        end
      end
      sck_p = s;
      lat_p = l;
      dat_p = d;
    end
  end

  // driver: pushes expected frames and checks busy length
  task automatic send(input logic [27:0] v, input logic [27:0] after,
                      input bit poke_mid, input logic [27:0] poke_val);
    int n;
    @(negedge clk);
    cfg_word = v;
    load_cmd = 1'b1;
    q_ab.push_back(v[11:0]);
    q_cd.push_back(v[23:12]);
    exp_frames++;
    @(negedge clk);
    load_cmd = 1'b0;
    cfg_word = after;  // R8: change the word after the command
    check(busy == 1'b1, "R7 busy rises", busy, 1);
    n = 0;
    while (busy) begin
      n++;
      load_cmd = poke_mid && (n == 20);  // R9: command while busy
      if (poke_mid && n == 20) cfg_word = poke_val;
      @(negedge clk);
    end
    load_cmd = 1'b0;
    check(n == 13 * DIV, "R7 busy length", n, 13 * DIV);
    repeat (3) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    logic [27:0] pats [5];
    nb[0] = 0; nb[1] = 0;
    sh[0] = '0; sh[1] = '0;
    rst_n = 1'b0;
    cfg_word = '0;
    load_cmd = 1'b0;
    repeat (3) @(negedge clk);
    // R1: state during reset
    check({busy, sclk_ab, sclk_cd, latch_ab, latch_cd, sdata_ab, sdata_cd} == 7'b0,
          "R1 reset outputs", {busy, sclk_ab, sclk_cd, latch_ab, latch_cd, sdata_ab, sdata_cd}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check({busy, sclk_ab, latch_ab, sdata_ab} == 4'b0, "R1 after release",
          {busy, sclk_ab, latch_ab, sdata_ab}, 0);
    mon_on = 1'b1;

    // R10: mux selects follow the word
    for (int i = 0; i < 4; i++) begin
      cfg_word = 28'h0123456 | (28'(4'b0001 << i) << 24) | (i == 3 ? 28'hA000000 : 28'h0);
      #1;
      check(ext_clk_sel == cfg_word[27:24], "R10 select passthrough",
            ext_clk_sel, cfg_word[27:24]);
    end

    // R2, R3: several patterns
    pats[0] = 28'h5A3C96E;
    pats[1] = 28'hFFFFFFF;
    pats[2] = 28'h0000001;
    pats[3] = 28'h8008008;
    pats[4] = 28'h1234567;
    for (int i = 0; i < 5; i++) send(pats[i], pats[i], 1'b0, '0);

    // R8: word changes right after the command
    send(28'h0ABC123, 28'hF543EDC, 1'b0, '0);
    // R9: a command in the middle of a frame
    send(28'h3F00FFF, 28'h3F00FFF, 1'b1, 28'h0C0F000);

    repeat (4 * DIV) @(negedge clk);
    check(busy == 1'b0, "R9 no extra load", busy, 0);
    check(got_frames == exp_frames && q_ab.size() == 0 && q_cd.size() == 0,
          "R9 frame count", got_frames, exp_frames);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule